// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. It is clocked by the test clock and steps through the sixteen-state controller sequence set by the mode-select input. An 8-bit instruction register, loaded serially, picks the data register that sits between the serial input and the serial output. The choices are a 1-bit bypass stage, a 32-bit identification word, a 32-bit user word, or an external boundary-scan chain. That chain is reached through a return input and three strobe outputs.

The decoded instruction also drives two pin-control outputs. One forces every pad driver to high impedance. The other makes the pads take their values from the boundary update latches; it is used for external test and for clamping. The serial output is launched on the falling test-clock edge, and an output-enable marks the two shift states. Opcodes the block does not recognise fall back to the bypass path. This keeps a chain of several devices usable with any instruction.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on each rising `tck` edge, including the pause and exit loops. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: `rst` high at a rising edge puts the controller in Test-Logic-Reset. Each edge spent in Test-Logic-Reset makes the active instruction the identification opcode 8'b11100000, with both pin controls low.
- R3: In Capture-IR the instruction shift stage loads 8'b00000001. In Shift-IR it shifts toward `tdo` with bit 0 first, taking `tdi` into bit 7.
- R4: The active instruction and its decoded outputs change only at Update-IR or Test-Logic-Reset. Shifting a new opcode leaves `pin_hiz` and `pin_from_latch` untouched until Update-IR.
- R5: Opcode 8'b11100000 selects the identification register. It captures 32'h012B0043 and shifts out least significant bit first, followed by `tdi` delayed 32 edges.
- R6: Opcode 8'b11000000 selects the user register. It captures 32'hFFFFFFFF and shifts in the same way.
- R7: Opcode 8'b11111111 selects the 1-bit bypass stage, which captures 0 in Capture-DR. So do 8'b01111000 (clamp), 8'b00011000 (high impedance) and every opcode not listed in R5, R6 and R8.
- R8: Opcodes 8'b00010101 (external test) and 8'b00011100 (sample and preload share this code) route the boundary chain. `bsr_capture`, `bsr_shift` and `bsr_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and `tdo` follows `bsc_so`.
- R9: `pin_hiz` is high only under 8'b00011000. `pin_from_latch` is high only under 8'b00010101 and 8'b01111000. The two are never high together.
- R10: `tdo` and `tdo_oe` change only on the falling `tck` edge. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R11: The three boundary strobes stay low whenever the active instruction does not select the boundary chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, also fed to the boundary chain |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_oe | output | 1 | Output enable for the `tdo` pad driver |
| bsc_so | input | 1 | Serial return from the last boundary cell |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift enable |
| bsr_update | output | 1 | Boundary chain update strobe |
| pin_hiz | output | 1 | Force all pad drivers to high impedance |
| pin_from_latch | output | 1 | Drive pads from boundary update latches |

## Verification
A wrong controller state shows at the ports within one or two edges. `tdo_oe` rises or falls at the wrong half-cycle, or a boundary strobe fires in the wrong state. A wrong instruction decode appears as soon as the next data scan: the scanned-out stream has the wrong length or the wrong captured prefix, so a misrouted path shows within the first 33 bits. A corrupted instruction shift stage appears in the Capture-IR pattern, or as a pin control that changes before Update-IR. Every 8-bit opcode is swept, and each result is compared against a stream computed from the opcode alone.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'hF,
    ST_IDLE    = 4'hC,
    ST_SEL_DR  = 4'h7,
    ST_CAP_DR  = 4'h6,
    ST_SH_DR   = 4'h2,
    ST_EX1_DR  = 4'h1,
    ST_PAU_DR  = 4'h3,
    ST_EX2_DR  = 4'h0,
    ST_UPD_DR  = 4'h5,
    ST_SEL_IR  = 4'h4,
    ST_CAP_IR  = 4'hE,
    ST_SH_IR   = 4'hA,
    ST_EX1_IR  = 4'h9,
    ST_PAU_IR  = 4'hB,
    ST_EX2_IR  = 4'h8,
    ST_UPD_IR  = 4'hD
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_USR = 2'd2,
    PATH_BSC = 2'd3
  } dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     hiz;
    logic     drive_latch;
  } ir_decode_t;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    unique case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int                IR_W      = 8,
  parameter logic [IR_W-1:0]   OP_IDCODE = 8'b11100000,
  parameter logic [IR_W-1:0]   OP_USER   = 8'b11000000,
  parameter logic [IR_W-1:0]   OP_EXTEST = 8'b00010101,
  parameter logic [IR_W-1:0]   OP_SAMPLE = 8'b00011100,
  parameter logic [IR_W-1:0]   OP_CLAMP  = 8'b01111000,
  parameter logic [IR_W-1:0]   OP_HIGHZ  = 8'b00011000
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_sr,
  output ir_decode_t      dec
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  function automatic ir_decode_t decode(input logic [IR_W-1:0] op);
    ir_decode_t d;
    d.path        = PATH_BYP;
    d.hiz         = 1'b0;
    d.drive_latch = 1'b0;
    if (op == OP_IDCODE)      d.path = PATH_ID;
    else if (op == OP_USER)   d.path = PATH_USR;
    else if (op == OP_EXTEST) begin
      d.path        = PATH_BSC;
      d.drive_latch = 1'b1;
    end
    else if (op == OP_SAMPLE) d.path = PATH_BSC;
    else if (op == OP_CLAMP)  d.drive_latch = 1'b1;
    else if (op == OP_HIGHZ)  d.hiz = 1'b1;
    return d;
  endfunction

  // serial stage: capture pattern, shift toward tdo
  always_ff @(posedge tck) begin
    if (rst)                    ir_sr <= IR_CAPTURE;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE;
    else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  // active instruction kept only in decoded, registered form
  always_ff @(posedge tck) begin
    if (rst || state == ST_RESET) dec <= decode(OP_IDCODE);
    else if (state == ST_UPD_IR)  dec <= decode(ir_sr);
  end

endmodule

// File: rtl/tap_const_sr.sv
`timescale 1ns/1ps
module tap_const_sr #(
  parameter int           W   = 32,
  parameter logic [W-1:0] CAP = '0
) (
  input  logic tck,
  input  logic rst,
  input  logic tdi,
  input  logic cap,
  input  logic sh,
  output logic lsb
);

  logic [W-1:0] sr;

  always_ff @(posedge tck) begin
    if (rst || cap) sr <= CAP;
    else if (sh)    sr <= {tdi, sr[W-1:1]};
  end

  assign lsb = sr[0];

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int             DR_W       = 32,
  parameter logic [DR_W-1:0] ID_VALUE   = 32'h012B0043,
  parameter logic [DR_W-1:0] USER_VALUE = '1
) (
  input  logic     tck,
  input  logic     rst,
  input  logic     tdi,
  input  logic     cap_dr,
  input  logic     sh_dr,
  input  dr_path_e path,
  input  logic     bsc_so,
  output logic     dr_tdo
);

  localparam int N_CONST = 2;

  logic [N_CONST-1:0] const_lsb;
  logic               byp;

  for (genvar g = 0; g < N_CONST; g++) begin : g_const
    localparam logic [DR_W-1:0] CV = (g == 0) ? ID_VALUE : USER_VALUE;
    localparam dr_path_e        PV = (g == 0) ? PATH_ID  : PATH_USR;
    tap_const_sr #(.W(DR_W), .CAP(CV)) u_sr (
      .tck (tck),
      .rst (rst),
      .tdi (tdi),
      .cap (cap_dr && path == PV),
      .sh  (sh_dr  && path == PV),
      .lsb (const_lsb[g])
    );
  end

  always_ff @(posedge tck) begin
    if (rst)                            byp <= 1'b0;
    else if (cap_dr && path == PATH_BYP) byp <= 1'b0;
    else if (sh_dr  && path == PATH_BYP) byp <= tdi;
  end

  always_comb begin
    unique case (path)
      PATH_ID:  dr_tdo = const_lsb[0];
      PATH_USR: dr_tdo = const_lsb[1];
      PATH_BSC: dr_tdo = bsc_so;
      default:  dr_tdo = byp;
    endcase
  end

endmodule

// File: rtl/jtag_tap_ctrl.sv
`timescale 1ns/1ps
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W       = 8,
  parameter int              DR_W       = 32,
  parameter logic [DR_W-1:0] ID_VALUE   = 32'h012B0043,
  parameter logic [DR_W-1:0] USER_VALUE = '1
) (
  input  logic tck,
  input  logic rst,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  input  logic bsc_so,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic pin_hiz,
  output logic pin_from_latch
);

  tap_state_e      state;
  logic [IR_W-1:0] ir_sr;
  ir_decode_t      dec;
  logic            dr_tdo;
  logic            bsc_sel;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  tap_ir #(.IR_W(IR_W)) u_ir (
    .tck   (tck),
    .rst   (rst),
    .tdi   (tdi),
    .state (state),
    .ir_sr (ir_sr),
    .dec   (dec)
  );

  tap_dr #(.DR_W(DR_W), .ID_VALUE(ID_VALUE), .USER_VALUE(USER_VALUE)) u_dr (
    .tck    (tck),
    .rst    (rst),
    .tdi    (tdi),
    .cap_dr (state == ST_CAP_DR),
    .sh_dr  (state == ST_SH_DR),
    .path   (dec.path),
    .bsc_so (bsc_so),
    .dr_tdo (dr_tdo)
  );

  assign bsc_sel        = (dec.path == PATH_BSC);
  assign bsr_capture    = bsc_sel && state == ST_CAP_DR;
  assign bsr_shift      = bsc_sel && state == ST_SH_DR;
  assign bsr_update     = bsc_sel && state == ST_UPD_DR;
  assign pin_hiz        = dec.hiz;
  assign pin_from_latch = dec.drive_latch;

  // serial output launched half a cycle after the shift edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == ST_SH_IR) ? ir_sr[0] : dr_tdo;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_chk
  import jtag_tap_pkg::*;
#(
  parameter int IR_W = 8
) (
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sr,
  input ir_decode_t      dec,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            pin_hiz,
  input logic            pin_from_latch,
  input logic            tdo_oe
);

  logic [2:0] high_run;

  always_ff @(posedge tck) begin
    if (rst)         high_run <= '0;
    else if (!tms)   high_run <= '0;
    else if (high_run != 3'd5) high_run <= high_run + 3'd1;
  end

  assert_five_high_reset_R1: assert property (@(posedge tck) disable iff (rst)
    (high_run == 3'd5) |-> (state == ST_RESET));

  assert_reset_state_R2: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |=> (dec.path == PATH_ID && !pin_hiz && !pin_from_latch));

  assert_capture_ir_R3: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_sr == {{(IR_W-2){1'b0}}, 2'b01}));

  assert_ir_hold_R4: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(dec));

  assert_strobe_onehot_R8: assert property (@(posedge tck) disable iff (rst)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  assert_pin_exclusive_R9: assert property (@(posedge tck) disable iff (rst)
    !(pin_hiz && pin_from_latch));

  assert_oe_shift_R10: assert property (@(posedge tck) disable iff (rst)
    tdo_oe == (state == ST_SH_IR || state == ST_SH_DR));

  assert_strobe_quiet_R11: assert property (@(posedge tck) disable iff (rst)
    (dec.path != PATH_BSC) |-> !(bsr_capture || bsr_shift || bsr_update));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk #(.IR_W(IR_W)) u_chk (
  .tck            (tck),
  .rst            (rst),
  .tms            (tms),
  .state          (state),
  .ir_sr          (ir_sr),
  .dec            (dec),
  .bsr_capture    (bsr_capture),
  .bsr_shift      (bsr_shift),
  .bsr_update     (bsr_update),
  .pin_hiz        (pin_hiz),
  .pin_from_latch (pin_from_latch),
  .tdo_oe         (tdo_oe)
);

// File: tb/jtag_tap_ctrl_test.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_test;

  logic tck = 1'b0;
  logic rst, tms, tdi;
  logic tdo, tdo_oe, bsc_so;
  logic bsr_capture, bsr_shift, bsr_update, pin_hiz, pin_from_latch;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [31:0] ID_EXP   = 32'h012B0043;
  localparam logic [3:0]  CHAIN_CV = 4'b1010;

  always #5 tck = ~tck;

  jtag_tap_ctrl uut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsc_so(bsc_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .pin_hiz(pin_hiz), .pin_from_latch(pin_from_latch)
  );

  // 4-cell boundary chain model
  logic [3:0] chain = 4'b0000;
  always @(posedge tck) begin
    if (bsr_capture)    chain <= CHAIN_CV;
    else if (bsr_shift) chain <= {tdi, chain[3:1]};
  end
  assign bsc_so = chain[0];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  function automatic logic [1:0] pins_of(input logic [7:0] op);
    // {hiz, from_latch}
    case (op)
      8'b00011000: return 2'b10;
      8'b00010101, 8'b01111000: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic is_bsc(input logic [7:0] op);
    return (op == 8'b00010101) || (op == 8'b00011100);
  endfunction

  function automatic logic [39:0] stream_of(input logic [7:0] op, input logic [39:0] din);
    int len;
    logic [31:0] cv;
    logic [39:0] r;
    case (op)
      8'b11100000: begin len = 32; cv = ID_EXP; end
      8'b11000000: begin len = 32; cv = '1; end
      8'b00010101, 8'b00011100: begin len = 4; cv = {28'd0, CHAIN_CV}; end
      default: begin len = 1; cv = '0; end
    endcase
    for (int i = 0; i < 40; i++) r[i] = (i < len) ? cv[i] : din[i-len];
    return r;
  endfunction

  // from Run-Test/Idle, load opcode; checks capture pattern and old pins before update
  task automatic load_ir(input logic [7:0] op, input logic [1:0] old_pins);
    logic [7:0] cap;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin
      cap[i] = tdo;
      step(i == 7, op[i]);
    end
    check("R3 capture-IR pattern", {56'd0, cap}, 64'h01);
    check("R4 pins held before Update-IR", {62'd0, pin_hiz, pin_from_latch}, {62'd0, old_pins});
    step(1, 0);
    step(0, 0);
  endtask

  task automatic scan_dr(input logic [39:0] din, output logic [39:0] dout,
                         output logic capv, output logic updv);
    step(1, 0); step(0, 0);
    capv = bsr_capture;
    step(0, 0);
    for (int i = 0; i < 40; i++) begin
      dout[i] = tdo;
      step(i == 39, din[i]);
    end
    step(1, 0);
    updv = bsr_update;
    step(0, 0);
  endtask

  initial begin
    logic [39:0] din, dout;
    logic capv, updv;
    logic [1:0] prev;
    rst = 1'b1; tms = 1'b1; tdi = 1'b0;
    @(negedge tck); #1;
    step(1, 0); step(1, 0);
    check("R2 reset pins", {62'd0, pin_hiz, pin_from_latch}, 64'd0);
    check("R10 reset tdo_oe", {63'd0, tdo_oe}, 64'd0);
    rst = 1'b0;
    step(0, 0);

    // R2/R5: reset instruction is identification
    din = 40'hA5_5A_C3_3C_96;
    scan_dr(din, dout, capv, updv);
    check("R5 identification after reset", {24'd0, dout}, {24'd0, stream_of(8'hE0, din)});

    // R10: falling-edge launch and enable window
    step(1, 0); step(0, 0);
    check("R10 tdo_oe low in Capture-DR", {63'd0, tdo_oe}, 64'd0);
    step(0, 0);
    check("R10 tdo_oe high in Shift-DR", {63'd0, tdo_oe}, 64'd1);
    check("R5 identification bit0", {63'd0, tdo}, 64'd1);
    step(0, 0);
    check("R5 identification bit1", {63'd0, tdo}, 64'd1);
    tms = 0; tdi = 0;
    @(posedge tck); #1;
    check("R10 tdo held after rising edge", {63'd0, tdo}, 64'd1);
    @(negedge tck); #1;
    check("R10 tdo changes on falling edge", {63'd0, tdo}, 64'd0);

    // R1: pause loop inside a scan: shift to exit, pause, back to shift
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 16; i++) begin dout[i] = tdo; step(i == 15, 1'b0); end
    step(0, 0); step(0, 0);
    check("R1 Pause-DR holds", {63'd0, tdo_oe}, 64'd0);
    step(1, 0); step(0, 0);
    for (int i = 16; i < 32; i++) begin dout[i] = tdo; step(i == 31, 1'b0); end
    step(1, 0); step(0, 0);
    check("R1 R5 scan across pause", {32'd0, dout[31:0]}, {32'd0, ID_EXP});

    // R1: five tms-high edges from Shift-DR reach reset
    load_ir(8'hFF, 2'b00);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    check("R1 tdo_oe low after five tms-high", {63'd0, tdo_oe}, 64'd0);
    step(0, 0);
    scan_dr(din, dout, capv, updv);
    check("R1 R2 instruction back to identification", {24'd0, dout}, {24'd0, stream_of(8'hE0, din)});

    // R2: synchronous reset while high impedance is active
    load_ir(8'b00011000, 2'b00);
    check("R9 high impedance active", {62'd0, pin_hiz, pin_from_latch}, 64'b10);
    rst = 1'b1;
    step(0, 0);
    rst = 1'b0;
    check("R2 reset clears pins", {62'd0, pin_hiz, pin_from_latch}, 64'd0);
    step(0, 0);
    scan_dr(din, dout, capv, updv);
    check("R2 identification after sync reset", {24'd0, dout}, {24'd0, stream_of(8'hE0, din)});

    // full opcode sweep: R3 R4 R5 R6 R7 R8 R9 R11
    prev = 2'b00;
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      load_ir(o, prev);
      check("R9 pin controls", {62'd0, pin_hiz, pin_from_latch}, {62'd0, pins_of(o)});
      din = {o, ~o, o ^ 8'hA5, 8'h3C, o + 8'd1};
      scan_dr(din, dout, capv, updv);
      check("R5 R6 R7 R8 scanned stream", {24'd0, dout}, {24'd0, stream_of(o, din)});
      check("R8 R11 capture strobe", {63'd0, capv}, {63'd0, is_bsc(o)});
      check("R8 R11 update strobe", {63'd0, updv}, {63'd0, is_bsc(o)});
      prev = pins_of(o);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge tck);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule